// File: doc/BRIEF.md
# Configurable Event Counter Bank

The block holds a bank of equal-width event counters, eight by default. Each counter picks one line from a vector of event inputs through its own select register. On every clock edge where the bank is enabled and that line is high, the counter advances by one. Two bitmask registers change how the counters behave. A cycle mask turns chosen counters into free-running clock counters. A pairing mask joins an even counter and the odd counter above it into one counter of twice the width.

Software reaches the bank through a single-beat register port. A request is sampled on a clock edge, and its response (valid, error flag and read data) appears in the cycle after that edge. Counters can be read and cleared through this port. They cannot be preset. When software reads the lower half of a joined pair, the upper half is captured at the same moment. The next read of the upper half returns that captured value, so the two reads form one consistent wide value.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, all counters, the enable bit, the cycle mask, the pairing mask and all select registers are zero, and `rsp_valid` is low.
- R2: Counter n increments by one on each clock edge where counting is enabled and event line `evt_in[s]` is high, where s is the value of counter n's select register.
- R3: While bit n of the cycle mask is set, counter n increments on every enabled clock edge, whatever its select value and the event inputs.
- R4: Bit 0 of the control register enables counting. While it is clear, every counter holds its value.
- R5: While pairing bit 2p is set, counter 2p is the lower half and counter 2p+1 the upper half of one wide counter. The upper half increments on exactly the edge where the lower half wraps from all-ones to zero.
- R6: In a joined pair, the odd counter's own cycle-mask bit and select value have no effect. The pair counts what the even counter's configuration selects.
- R7: Pairing-mask bits at odd positions are reserved. They always read as zero, and writes to them are dropped.
- R8: Writing zero to a counter register clears that counter on the same edge, even if the counter would have incremented there.
- R9: Writing a nonzero value to a counter register returns an error response and leaves the counter unchanged.
- R10: An access to an unmapped address returns an error response with read data zero and changes no state.
- R11: Reading the lower half of a joined pair captures the upper half. The next read of that upper half returns the captured value; later reads return the live value.
- R12: A write to a select register, the cycle mask or the pairing mask takes effect from the next clock edge and does not change any counter value.
- R13: Every request sampled on an edge gets exactly one response cycle with `rsp_valid` high right after that edge. The word addresses are: 0 control, 1 cycle mask, 2 pairing mask, NUM_CTR+n select of counter n, and 2*NUM_CTR+n counter n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | Event lines that counters select from |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the register |
| req_wdata | input | CTR_W | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | CTR_W | Read data (zero on error or write) |

## Verification
The hardest situations to reach from the ports are a carry from the lower half into the upper half, and a snapshot read that lands right at that carry. With full-width counters, the first one needs billions of cycles. The bench therefore builds the bank with 8-bit counters. It lets a joined pair count clock cycles until the lower half sits at all-ones, then reads the lower half in exactly that cycle. The upper-half read that follows has to return the captured zero, even though the live value has already moved to one. A separate run of more than 65,536 cycles makes the whole 16-bit pair wrap, and the upper-half carry is checked against plain modular arithmetic.

// File: rtl/evb_pkg.sv
package evb_pkg;

    // Kind of register a request address decodes to.
    typedef enum logic [2:0] {
        RK_CTRL,
        RK_CYC,
        RK_PAIR,
        RK_SEL,
        RK_CNT,
        RK_NONE
    } reg_kind_e;

endpackage

// File: rtl/evb_pair.sv
// One even/odd counter pair, optionally joined into a double-width counter.
module evb_pair #(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 16,
    parameter int SEL_W   = $clog2(NUM_EVT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [NUM_EVT-1:0] evt,
    input  logic             cyc_lo,
    input  logic             cyc_hi,
    input  logic [SEL_W-1:0] sel_lo,
    input  logic [SEL_W-1:0] sel_hi,
    input  logic             fuse,
    input  logic             clr_lo,
    input  logic             clr_hi,
    output logic [CTR_W-1:0] cnt_lo,
    output logic [CTR_W-1:0] cnt_hi
);

    typedef struct packed {
        logic [CTR_W-1:0] lo;
        logic [CTR_W-1:0] hi;
    } pair_state_t;

    pair_state_t st_d, st_q;

    logic hit_lo, hit_hi;
    logic inc_lo, inc_hi_own, wrap_lo, inc_hi;

    // Event line picked by each select value; values past NUM_EVT pick nothing.
    always_comb begin
        hit_lo = 1'b0;
        hit_hi = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (sel_lo == SEL_W'(e)) hit_lo = evt[e];
            if (sel_hi == SEL_W'(e)) hit_hi = evt[e];
        end
    end

    always_comb begin
        inc_lo     = enable & (cyc_lo | hit_lo);
        inc_hi_own = enable & (cyc_hi | hit_hi);
        wrap_lo    = inc_lo & (st_q.lo == '1) & ~clr_lo;
        inc_hi     = fuse ? wrap_lo : inc_hi_own;

        st_d = st_q;
        if (clr_lo)      st_d.lo = '0;
        else if (inc_lo) st_d.lo = st_q.lo + CTR_W'(1);
        if (clr_hi)      st_d.hi = '0;
        else if (inc_hi) st_d.hi = st_q.hi + CTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_lo = st_q.lo;
    assign cnt_hi = st_q.hi;

    // A cycle-counting lower half advances by exactly one per enabled edge.
    assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enable && cyc_lo && !clr_lo |=> st_q.lo == $past(st_q.lo) + CTR_W'(1));

    // With the bank disabled and no clear, nothing moves.
    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !clr_lo && !clr_hi |=> $stable(st_q.lo) && $stable(st_q.hi));

    // Joined pair: the upper half changes exactly when the lower half wraps.
    assert_carry_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fuse && !clr_lo && !clr_hi |=>
            ((st_q.hi != $past(st_q.hi)) == (($past(st_q.lo) == '1) && (st_q.lo == '0))));

    // Joined pair: the odd side's own configuration cannot move the upper half.
    assert_odd_cfg_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fuse && !clr_hi && !(inc_lo && st_q.lo == '1) |=> $stable(st_q.hi));

    // A clear wins over a same-edge increment.
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lo |=> st_q.lo == '0);

endmodule

// File: rtl/evb_regif.sv
// Register decode, configuration state, upper-half snapshot and response path.
module evb_regif
    import evb_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 32,
    parameter int SEL_W   = 4,
    parameter int ADDR_W  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [CTR_W-1:0]                req_wdata,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]   cnt_val,
    output logic                            rsp_valid,
    output logic                            rsp_err,
    output logic [CTR_W-1:0]                rsp_rdata,
    output logic                            enable,
    output logic [NUM_CTR-1:0]              cyc_mask,
    output logic [NUM_CTR-1:0]              pair_mask,
    output logic [NUM_CTR-1:0][SEL_W-1:0]   sel,
    output logic [NUM_CTR-1:0]              clr
);

    localparam int NUM_PAIR  = NUM_CTR / 2;
    localparam int IDX_W     = $clog2(NUM_CTR);
    localparam int CTRL_ADDR = 0;
    localparam int CYC_ADDR  = 1;
    localparam int PAIR_ADDR = 2;
    localparam int SEL_BASE  = NUM_CTR;
    localparam int CNT_BASE  = 2 * NUM_CTR;
    localparam logic [NUM_CTR-1:0] EVEN_MASK = {NUM_PAIR{2'b01}};

    typedef struct packed {
        logic                           en;
        logic [NUM_CTR-1:0]             cyc;
        logic [NUM_CTR-1:0]             pair;
        logic [NUM_CTR-1:0][SEL_W-1:0]  sel;
        logic [NUM_PAIR-1:0][CTR_W-1:0] shadow;
        logic [NUM_PAIR-1:0]            shv;
        logic                           rsp_valid;
        logic                           rsp_err;
        logic [CTR_W-1:0]               rdata;
    } regif_state_t;

    regif_state_t st_d, st_q;
    reg_kind_e    kind;
    logic [IDX_W-1:0] idx;

    // Address decode.
    always_comb begin
        kind = RK_NONE;
        idx  = '0;
        if (req_addr == ADDR_W'(CTRL_ADDR)) kind = RK_CTRL;
        if (req_addr == ADDR_W'(CYC_ADDR))  kind = RK_CYC;
        if (req_addr == ADDR_W'(PAIR_ADDR)) kind = RK_PAIR;
        for (int n = 0; n < NUM_CTR; n++) begin
            if (req_addr == ADDR_W'(SEL_BASE + n)) begin
                kind = RK_SEL;
                idx  = IDX_W'(n);
            end
            if (req_addr == ADDR_W'(CNT_BASE + n)) begin
                kind = RK_CNT;
                idx  = IDX_W'(n);
            end
        end
    end

    // Next-state computation.
    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = 1'b0;
        st_d.rdata     = '0;
        clr            = '0;
        if (req_valid) begin
            unique case (kind)
                RK_CTRL: begin
                    if (req_write) st_d.en = req_wdata[0];
                    else           st_d.rdata = CTR_W'(st_q.en);
                end
                RK_CYC: begin
                    if (req_write) st_d.cyc = req_wdata[NUM_CTR-1:0];
                    else           st_d.rdata = CTR_W'(st_q.cyc);
                end
                RK_PAIR: begin
                    if (req_write) st_d.pair = req_wdata[NUM_CTR-1:0] & EVEN_MASK;
                    else           st_d.rdata = CTR_W'(st_q.pair);
                end
                RK_SEL: begin
                    if (req_write) st_d.sel[idx] = req_wdata[SEL_W-1:0];
                    else           st_d.rdata = CTR_W'(st_q.sel[idx]);
                end
                RK_CNT: begin
                    if (req_write) begin
                        if (req_wdata == '0) clr[idx] = 1'b1;
                        else                 st_d.rsp_err = 1'b1;
                    end else begin
                        st_d.rdata = cnt_val[idx];
                        for (int p = 0; p < NUM_PAIR; p++) begin
                            if (st_q.pair[2*p]) begin
                                if (idx == IDX_W'(2*p)) begin
                                    st_d.shadow[p] = cnt_val[2*p+1];
                                    st_d.shv[p]    = 1'b1;
                                end
                                if (idx == IDX_W'(2*p+1) && st_q.shv[p]) begin
                                    st_d.rdata  = st_q.shadow[p];
                                    st_d.shv[p] = 1'b0;
                                end
                            end
                        end
                    end
                end
                default: st_d.rsp_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rdata;
    assign enable    = st_q.en;
    assign cyc_mask  = st_q.cyc;
    assign pair_mask = st_q.pair;
    assign sel       = st_q.sel;

    assert_rsp_follows_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_cnt_nonzero_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && kind == RK_CNT && req_wdata != '0 |=> rsp_err);

    assert_unmapped_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && kind == RK_NONE |=> rsp_err && rsp_rdata == '0);

    assert_odd_pair_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && kind == RK_PAIR |=> (pair_mask & ~EVEN_MASK) == '0);

endmodule

// File: rtl/evt_counter_bank.sv
// Bank of event counters with cycle-count and pairing masks.
module evt_counter_bank #(
    parameter  int NUM_CTR = 8,
    parameter  int CTR_W   = 32,
    parameter  int NUM_EVT = 16,
    localparam int ADDR_W  = $clog2(3 * NUM_CTR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [CTR_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [CTR_W-1:0]   rsp_rdata
);

    localparam int NUM_PAIR = NUM_CTR / 2;
    localparam int SEL_W    = $clog2(NUM_EVT);

    logic                          enable;
    logic [NUM_CTR-1:0]            cyc_mask;
    logic [NUM_CTR-1:0]            pair_mask;
    logic [NUM_CTR-1:0][SEL_W-1:0] sel;
    logic [NUM_CTR-1:0]            clr;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_val;

    initial begin
        assert_cfg_shape: assert (NUM_CTR % 2 == 0 && NUM_CTR >= 4 &&
                                  CTR_W >= NUM_CTR && CTR_W >= SEL_W && NUM_EVT >= 2);
    end

    evb_regif #(
        .NUM_CTR(NUM_CTR),
        .CTR_W  (CTR_W),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .cnt_val  (cnt_val),
        .rsp_valid(rsp_valid),
        .rsp_err  (rsp_err),
        .rsp_rdata(rsp_rdata),
        .enable   (enable),
        .cyc_mask (cyc_mask),
        .pair_mask(pair_mask),
        .sel      (sel),
        .clr      (clr)
    );

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        evb_pair #(
            .CTR_W  (CTR_W),
            .NUM_EVT(NUM_EVT),
            .SEL_W  (SEL_W)
        ) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(enable),
            .evt   (evt_in),
            .cyc_lo(cyc_mask[2*p]),
            .cyc_hi(cyc_mask[2*p+1]),
            .sel_lo(sel[2*p]),
            .sel_hi(sel[2*p+1]),
            .fuse  (pair_mask[2*p]),
            .clr_lo(clr[2*p]),
            .clr_hi(clr[2*p+1]),
            .cnt_lo(cnt_val[2*p]),
            .cnt_hi(cnt_val[2*p+1])
        );
    end

endmodule

// File: tb/evt_counter_bank_tb_top.sv
module evt_counter_bank_tb_top;

    localparam int NC = 8;
    localparam int CW = 8;
    localparam int NE = 8;
    localparam int AW = $clog2(3 * NC);
    localparam int SELB = NC;
    localparam int CNTB = 2 * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_in = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [CW-1:0] rsp_rdata;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    int selv[NC];
    int tally[NE];

    always #4 clk = ~clk;

    evt_counter_bank #(.NUM_CTR(NC), .CTR_W(CW), .NUM_EVT(NE)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input int addr, input int data,
                          output int rd, output int er);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_wdata = CW'(data);
        @(negedge clk);
        check("R13 response valid", int'(rsp_valid), 1);
        rd = int'(rsp_rdata);
        er = int'(rsp_err);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
    endtask

    task automatic wr(input int addr, input int data);
        int rd, er;
        access(1'b1, addr, data, rd, er);
        if (er != 0) check("R13 write accepted", er, 0);
    endtask

    task automatic rdchk(input string req, input int addr, input int exp);
        int rd, er;
        access(1'b0, addr, 0, rd, er);
        check(req, rd, exp);
    endtask

    initial begin
        int rd, er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rsp_valid idle", int'(rsp_valid), 0);
        rdchk("R1 control", 0, 0);
        rdchk("R1 cycle mask", 1, 0);
        rdchk("R1 pairing mask", 2, 0);
        for (int n = 0; n < NC; n++) rdchk("R1 counter", CNTB + n, 0);
        @(negedge clk);
        check("R13 valid drops", int'(rsp_valid), 0);

        // Sweep A: all counters separate, two in cycle mode (R2, R3)
        for (int n = 0; n < NC; n++) begin
            selv[n] = (3 * n + 1) % NE;
            wr(SELB + n, selv[n]);
        end
        wr(1, 8'h84);
        for (int j = 0; j < NE; j++) tally[j] = 0;
        wr(0, 1);
        for (int i = 0; i < 200; i++) begin
            for (int j = 0; j < NE; j++) begin
                evt_in[j] = ((i + j) % (j + 2)) == 0;
                if (evt_in[j]) tally[j]++;
            end
            @(negedge clk);
        end
        evt_in = '0;
        wr(0, 0);
        for (int n = 0; n < NC; n++) begin
            if (n == 2 || n == 7) rdchk("R3 cycle count", CNTB + n, 201);
            else                  rdchk("R2 event count", CNTB + n, tally[selv[n]] % 256);
        end

        // R4: disabled bank holds
        evt_in = '1;
        repeat (20) @(negedge clk);
        evt_in = '0;
        rdchk("R4 hold event counter", CNTB + 0, tally[selv[0]] % 256);
        rdchk("R4 hold cycle counter", CNTB + 2, 201);

        // R12: config change keeps values
        selv[0] = 5;
        wr(SELB + 0, 5);
        wr(1, 8'h85);
        rdchk("R12 select change keeps value", CNTB + 0, tally[1] % 256);
        rdchk("R12 select readback", SELB + 0, 5);

        // R9: nonzero counter write rejected
        access(1'b1, CNTB + 3, 5, rd, er);
        check("R9 error flag", er, 1);
        rdchk("R9 counter unchanged", CNTB + 3, tally[selv[3]] % 256);

        // R10: unmapped addresses
        access(1'b0, 5, 0, rd, er);
        check("R10 read error", er, 1);
        check("R10 read data zero", rd, 0);
        access(1'b1, 31, 7, rd, er);
        check("R10 write error", er, 1);
        rdchk("R10 cycle mask untouched", 1, 8'h85);

        // R8: clear all
        for (int n = 0; n < NC; n++) wr(CNTB + n, 0);
        for (int n = 0; n < NC; n++) rdchk("R8 cleared", CNTB + n, 0);

        // R7: reserved pairing bits
        wr(2, 8'hFF);
        rdchk("R7 odd pairing bits zero", 2, 8'h55);

        // Sweep B: pairs 0 and 1 joined, odd config bits set and ignored (R5, R6)
        wr(2, 8'h05);
        wr(1, 8'h0B);
        selv[3] = 6;
        wr(SELB + 3, 6);
        for (int j = 0; j < NE; j++) tally[j] = 0;
        wr(0, 1);
        for (int i = 0; i < 600; i++) begin
            for (int j = 0; j < NE; j++) begin
                evt_in[j] = ((i + j) % 5) != 0;
                if (evt_in[j]) tally[j]++;
            end
            @(negedge clk);
        end
        evt_in = '0;
        wr(0, 0);
        rdchk("R5 cycle pair low", CNTB + 0, 601 % 256);
        rdchk("R6 cycle pair high", CNTB + 1, 601 / 256);
        rdchk("R5 event pair low", CNTB + 2, tally[selv[2]] % 256);
        rdchk("R6 event pair high", CNTB + 3, tally[selv[2]] / 256);
        for (int n = 4; n < NC; n++)
            rdchk("R2 separate counter wraps", CNTB + n, tally[selv[n]] % 256);

        // Sweep C: snapshot at the carry point (R11) and clear while counting (R8)
        for (int n = 0; n < NC; n++) wr(CNTB + n, 0);
        wr(2, 8'h01);
        wr(1, 8'h11);
        wr(0, 1);
        repeat (255) @(negedge clk);
        rdchk("R11 low half at all-ones", CNTB + 0, 255);
        rdchk("R11 captured high half", CNTB + 1, 0);
        rdchk("R11 live high half", CNTB + 1, 1);
        wr(CNTB + 4, 0);
        rdchk("R8 clear wins over increment", CNTB + 4, 0);
        wr(0, 0);

        // Sweep D: long run wraps 16 bits (R5)
        wr(CNTB + 0, 0);
        wr(CNTB + 1, 0);
        wr(0, 1);
        repeat (66000) @(negedge clk);
        wr(0, 0);
        rdchk("R5 long run low", CNTB + 0, 66001 % 256);
        rdchk("R5 long run high", CNTB + 1, (66001 / 256) % 256);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule